// File: doc/BRIEF.md
# Toggle-Bit Completion Poller for Flash Program and Erase

This block runs on the host side of a parallel flash bus. It decides when an embedded program or erase operation inside the flash has ended. After the command sequence has been written, a one-cycle `start` pulse tells the poller that the last write pulse has gone out. The poller then makes status reads on a simple request/acknowledge port and compares the toggle bit (data bit 6) of each read with the one before. When two back-to-back reads agree, the operation is over and `done` pulses.

Data bit 5 is the flash's timeout flag. This flag also appears after a successful finish, so the poller never acts on it alone. When it sees the flag, it makes two more reads and checks whether bit 6 is still changing. Only a toggle in that pair counts as a real failure. In that case the poller writes the reset command to the flash, so that the flash goes back to returning array data, and then pulses `fail`. An optional read budget ends an operation that never settles and never raises the timeout flag, through the same reset-and-fail exit.

Top module: `tbit_poller`

## Requirements
- R1: While reset is held, and right after it, `busy`, `done`, `fail`, `bus_req` and `bus_we` are all low.
- R2: A `start` pulse while the poller is idle raises `busy` and `bus_req` (a read, `bus_we` low) in the cycle after the pulse. A `start` pulse while busy has no effect on the read count or the outcome.
- R3: Every bus transaction uses address `POLL_ADDR`. A request stays asserted, with `bus_we` unchanged, until the cycle in which `bus_ack` is sampled high. `bus_ack` is a one-cycle strobe, and `bus_rdata` is valid with it.
- R4: The operation counts as finished when bit 6 of a read equals bit 6 of the read just before it. `done` is then high for exactly one cycle, in the cycle after that read's acknowledge, with `busy` low. No further read is made.
- R5: When a read shows bit 5 = 1 and bit 6 differs from the previous read, exactly two more reads follow. If bit 6 of those two reads is equal, the result is `done`, with no write.
- R6: If bit 6 of those two re-check reads differs, the poller makes one write of data F0h (`bus_we` high). `fail` is high for exactly one cycle, in the cycle after that write's acknowledge, with `busy` low.
- R7: With `MAX_POLLS` nonzero, the poller stops after the `MAX_POLLS`-th read that still shows toggling with bit 5 = 0, and takes the R6 write-and-fail exit. With `MAX_POLLS` = 0, there is no limit.
- R8: `done` and `fail` are never high together, and neither is high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse after the final command write |
| bus_req | output | 1 | Transaction request, held until acknowledged |
| bus_we | output | 1 | 1 = write (reset command), 0 = status read |
| bus_addr | output | AW | Transaction address (constant `POLL_ADDR`) |
| bus_wdata | output | DW | Write data (reset command F0h) |
| bus_ack | input | 1 | One-cycle acknowledge; read data valid with it |
| bus_rdata | input | DW | Status read data |
| busy | output | 1 | Poll sequence in progress |
| done | output | 1 | One-cycle pulse: operation finished |
| fail | output | 1 | One-cycle pulse: operation failed, reset command sent |

## Verification
The bus responder acknowledges each request after a chosen number of wait cycles. It returns a status word from a per-case script of when bit 6 stops toggling and when bit 5 rises. `busy` and `bus_req` are due one cycle after the clock edge that samples `start`. `done` or `fail` is due one cycle after the edge that samples the final acknowledge, and `busy` falls in that same cycle.

A behavioural model in the bench advances its expected outputs from the `start` and `bus_ack` values it recorded at each rising edge. It compares them with the design's outputs at the following falling edge, every cycle, so every result is checked in the exact cycle it is due. Read counts, the write data and the number of pulses are checked once the poller is idle again.

// File: rtl/tbit_pkg.sv
// Package tbit_pkg
// Shared types and bit positions for the toggle-bit poller.
// Assumes the flash status word carries the toggle flag in bit 6
// and the timeout flag in bit 5.
package tbit_pkg;

    // Status bit that alternates on each read while the flash is busy
    localparam int TOGGLE_IDX  = 6;
    // Status bit that signals the flash's internal time limit
    localparam int TIMEOUT_IDX = 5;

    // Sequencer states
    typedef enum logic [2:0] {
        PS_IDLE,    // waiting for start
        PS_FIRST,   // first status read, reference only
        PS_POLL,    // repeated status reads with comparison
        PS_CHK_A,   // first re-check read after timeout flag
        PS_CHK_B,   // second re-check read, compared with A
        PS_RESET,   // reset-command write
        PS_DONE,    // one-cycle completion pulse
        PS_FAIL     // one-cycle failure pulse
    } poll_state_t;

endpackage

// File: rtl/tbit_cmp.sv
// Module tbit_cmp
// Holds the toggle bit of the most recent captured read and compares it
// with the status word now on the bus. Also extracts the timeout flag.
// Assumes rdata is valid whenever cap_en is high (acknowledge cycle).
module tbit_cmp
    import tbit_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic [DW-1:0] rdata,
    output logic          same_bit,
    output logic          timeout_bit
);

    logic ref_q;

    // Capture the toggle bit of each accepted read as the next reference
    always_ff @(posedge clk) begin
        if (!rst_n)
            ref_q <= 1'b0;
        else if (cap_en)
            ref_q <= rdata[TOGGLE_IDX];
    end

    // Compare current read with the stored reference
    always_comb begin
        same_bit    = (rdata[TOGGLE_IDX] == ref_q);
        timeout_bit = rdata[TIMEOUT_IDX];
    end

    // Other status bits carry no meaning for this block
    logic unused_bits;
    assign unused_bits = ^rdata;

endmodule

// File: rtl/tbit_pollcnt.sv
// Module tbit_pollcnt
// Counts accepted polling reads and reports when the current read is the
// last one allowed by MAX_POLLS. With MAX_POLLS = 0 no counter is built
// and the limit never trips.
module tbit_pollcnt #(
    parameter int MAX_POLLS = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic limit_hit
);

    localparam int CW = (MAX_POLLS < 2) ? 1 : $clog2(MAX_POLLS + 1);

    generate
        if (MAX_POLLS == 0) begin : g_unlimited
            assign limit_hit = 1'b0;
            logic unused_in;
            assign unused_in = ^{clk, rst_n, clr, inc};
        end else begin : g_limited
            logic [CW-1:0] cnt_q;

            // Saturating count of polling reads since start
            always_ff @(posedge clk) begin
                if (!rst_n || clr)
                    cnt_q <= '0;
                else if (inc && (cnt_q != CW'(MAX_POLLS)))
                    cnt_q <= cnt_q + 1'b1;
            end

            // The read being accepted now is number cnt_q+1
            assign limit_hit = (int'(cnt_q) + 1) >= MAX_POLLS;

            // Count never passes the budget
            assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
                int'(cnt_q) <= MAX_POLLS);
        end
    endgenerate

endmodule

// File: rtl/tbit_fsm.sv
// Module tbit_fsm
// Sequencer of the toggle-bit poller: issues status reads, interprets the
// comparison and timeout results, confirms a timeout by a read pair, and
// issues the reset-command write on failure.
// Assumes bus_ack is a one-cycle strobe given only while bus_req is high.
module tbit_fsm
    import tbit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic bus_ack,
    input  logic same_bit,
    input  logic timeout_bit,
    input  logic limit_hit,
    output logic bus_req,
    output logic bus_we,
    output logic busy,
    output logic done,
    output logic fail,
    output logic cap_en,
    output logic cnt_clr,
    output logic cnt_inc
);

    poll_state_t state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= PS_IDLE;
        else
            state_q <= state_d;
    end

    // Next-state and per-cycle control decisions
    always_comb begin
        state_d = state_q;
        cap_en  = 1'b0;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        unique case (state_q)
            PS_IDLE: begin
                if (start) begin
                    state_d = PS_FIRST;
                    cnt_clr = 1'b1;
                end
            end
            PS_FIRST: begin
                if (bus_ack) begin
                    cap_en  = 1'b1;
                    cnt_inc = 1'b1;
                    state_d = PS_POLL;
                end
            end
            PS_POLL: begin
                if (bus_ack) begin
                    cap_en  = 1'b1;
                    cnt_inc = 1'b1;
                    if (same_bit)
                        state_d = PS_DONE;
                    else if (timeout_bit)
                        state_d = PS_CHK_A;
                    else if (limit_hit)
                        state_d = PS_RESET;
                end
            end
            PS_CHK_A: begin
                if (bus_ack) begin
                    cap_en  = 1'b1;
                    state_d = PS_CHK_B;
                end
            end
            PS_CHK_B: begin
                if (bus_ack)
                    state_d = same_bit ? PS_DONE : PS_RESET;
            end
            PS_RESET: begin
                if (bus_ack)
                    state_d = PS_FAIL;
            end
            PS_DONE:  state_d = PS_IDLE;
            PS_FAIL:  state_d = PS_IDLE;
            default:  state_d = PS_IDLE;
        endcase
    end

    // Outputs decoded from the registered state
    always_comb begin
        bus_req = (state_q == PS_FIRST) || (state_q == PS_POLL)  ||
                  (state_q == PS_CHK_A) || (state_q == PS_CHK_B) ||
                  (state_q == PS_RESET);
        bus_we  = (state_q == PS_RESET);
        busy    = bus_req;
        done    = (state_q == PS_DONE);
        fail    = (state_q == PS_FAIL);
    end

    assert_start_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_IDLE && start) |=> (bus_req && busy && !bus_we));

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we)));

    assert_done_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(bus_ack && !bus_we));

    assert_fail_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> $past(bus_ack && bus_we));

    assert_pulse_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_fail_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> !fail);

endmodule

// File: rtl/tbit_poller.sv
// Module tbit_poller
// Host-side toggle-bit completion poller for flash program/erase.
// Assumes start is pulsed only after the final command write pulse and
// that the bus port answers each request with a one-cycle acknowledge.
module tbit_poller #(
    parameter int             DW        = 8,
    parameter int             AW        = 20,
    parameter logic [AW-1:0]  POLL_ADDR = '0,
    parameter logic [DW-1:0]  RESET_CMD = DW'(8'hF0),
    parameter int             MAX_POLLS = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_ack,
    input  logic [DW-1:0] bus_rdata,
    output logic          busy,
    output logic          done,
    output logic          fail
);

    logic same_bit, timeout_bit, limit_hit;
    logic cap_en, cnt_clr, cnt_inc;

    // Comparison of successive toggle bits
    tbit_cmp #(.DW(DW)) cmp_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_en      (cap_en),
        .rdata       (bus_rdata),
        .same_bit    (same_bit),
        .timeout_bit (timeout_bit)
    );

    // Optional polling budget
    tbit_pollcnt #(.MAX_POLLS(MAX_POLLS)) cnt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cnt_clr),
        .inc       (cnt_inc),
        .limit_hit (limit_hit)
    );

    // Sequencer
    tbit_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .bus_ack     (bus_ack),
        .same_bit    (same_bit),
        .timeout_bit (timeout_bit),
        .limit_hit   (limit_hit),
        .bus_req     (bus_req),
        .bus_we      (bus_we),
        .busy        (busy),
        .done        (done),
        .fail        (fail),
        .cap_en      (cap_en),
        .cnt_clr     (cnt_clr),
        .cnt_inc     (cnt_inc)
    );

    // Status may be read at any address; one fixed address serves all
    assign bus_addr  = POLL_ADDR;
    assign bus_wdata = RESET_CMD;

endmodule

// File: tb/tbit_poller_tb.sv
module tbit_poller_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int            DW    = 8;
    localparam int            AW    = 16;
    localparam logic [AW-1:0] PADDR = 16'h0555;
    localparam int            MAXP  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          bus_ack = 1'b0;
    logic [DW-1:0] bus_rdata = '0;
    logic          bus_req, bus_we, busy, done, fail;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;

    tbit_poller #(.DW(DW), .AW(AW), .POLL_ADDR(PADDR), .MAX_POLLS(MAXP)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .busy(busy), .done(done), .fail(fail)
    );

    always #10 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    int g_T = 1, g_F = 1000000, lat = 0, wait_c = 0;
    int exp_reads = 0, rd_k = 0, wr_n = 0, n_done = 0, n_fail = 0;
    bit exp_fail = 0, ack_final = 0, mon_on = 0;
    bit m_busy = 0, m_done = 0, m_fail = 0;
    bit e_start = 0, e_ack = 0, e_final = 0;

    task automatic chk(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, expv, $time);
        end
    endtask

    // Toggle-bit value of the k-th read for a given stop point T
    function automatic int d6(int k, int T);
        return (k < T) ? (k & 1) : ((T - 1) & 1);
    endfunction

    function automatic logic [7:0] gen(int k);
        logic b6, b5;
        b6 = d6(k, g_T) != 0;
        b5 = (k >= g_F);
        return {1'b0, b6, b5, 5'b01010};
    endfunction

    // Expected read count and outcome from the requirements
    task automatic ref_walk(input int T, input int F, input int mx,
                            output int nr, output bit nf);
        int prev;
        nr = 0; nf = 0;
        prev = d6(0, T);
        for (int k = 1; k < 1000000; k++) begin
            if (d6(k, T) == prev) begin nr = k + 1; return; end
            if (k >= F) begin
                nr = k + 3; nf = (d6(k + 1, T) != d6(k + 2, T)); return;
            end
            if (mx != 0 && k + 1 >= mx) begin nr = k + 1; nf = 1; return; end
            prev = d6(k, T);
        end
    endtask

    // Record what the design saw at each rising edge
    always @(posedge clk) begin
        e_start = start;
        e_ack   = bus_ack;
        e_final = ack_final;
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Reference model, per-cycle comparison and bus responder
    always @(negedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_fail = 0;
            bus_ack = 0; ack_final = 0; wait_c = 0;
        end else begin
            if (m_busy) begin
                if (e_ack && e_final) begin
                    m_busy = 0; m_done = !exp_fail; m_fail = exp_fail;
                end
            end else if (m_done || m_fail) begin
                m_done = 0; m_fail = 0;
            end else if (e_start) begin
                m_busy = 1;
            end
            if (mon_on) begin
                chk(busy == m_busy,    "R2 busy",    int'(busy),    int'(m_busy));
                chk(bus_req == m_busy, "R3 bus_req", int'(bus_req), int'(m_busy));
                chk(done == m_done,    "R4 done",    int'(done),    int'(m_done));
                chk(fail == m_fail,    "R6 fail",    int'(fail),    int'(m_fail));
                chk(!(done && fail),   "R8 excl",    int'(done && fail), 0);
            end
            n_done += int'(done);
            n_fail += int'(fail);
            if (bus_ack) begin
                bus_ack = 0; ack_final = 0;
            end else if (bus_req) begin
                if (wait_c >= lat) begin
                    wait_c = 0;
                    bus_ack = 1;
                    chk(bus_addr == PADDR, "R3 addr", int'(bus_addr), int'(PADDR));
                    if (bus_we) begin
                        wr_n++;
                        chk(bus_wdata == 8'hF0, "R6 wdata", int'(bus_wdata), 240);
                        ack_final = 1;
                    end else begin
                        bus_rdata = gen(rd_k);
                        rd_k++;
                        chk(rd_k <= exp_reads, "R4 no extra read", rd_k, exp_reads);
                        ack_final = (!exp_fail && rd_k == exp_reads);
                    end
                end else begin
                    wait_c++;
                end
            end
        end
    end

    task automatic run_case(string tag, int T, int F, int l, bit poke);
        int tr;
        bit tf;
        g_T = T; g_F = F; lat = l; wait_c = 0;
        rd_k = 0; wr_n = 0; n_done = 0; n_fail = 0;
        ref_walk(T, F, MAXP, tr, tf);
        exp_reads = tr; exp_fail = tf;
        @(negedge clk); #1 start = 1;
        @(negedge clk); #1 start = 0;
        if (poke) begin
            repeat (5) @(negedge clk);
            #1 start = 1;
            @(negedge clk); #1 start = 0;
        end
        do @(negedge clk); while (busy || done || fail);
        repeat (3) @(negedge clk);
        chk(rd_k == tr,              {tag, " read count"}, rd_k, tr);
        chk(wr_n == int'(tf),        {tag, " reset writes"}, wr_n, int'(tf));
        chk(n_done == int'(!tf),     {tag, " done pulses"}, n_done, int'(!tf));
        chk(n_fail == int'(tf),      {tag, " fail pulses"}, n_fail, int'(tf));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !fail && !bus_req && !bus_we, "R1 during reset",
            int'({busy, done, fail, bus_req, bus_we}), 0);
        #1 rst_n = 1;
        @(negedge clk);
        chk(!busy && !done && !fail && !bus_req && !bus_we, "R1 after reset",
            int'({busy, done, fail, bus_req, bus_we}), 0);
        mon_on = 1;
        run_case("R4 immediate stop",            1,    1000000, 0, 0);
        run_case("R4 normal finish wait states", 6,    1000000, 2, 0);
        run_case("R4 protected early stop",      3,    1000000, 1, 0);
        run_case("R5 R6 confirmed timeout",      1000, 5,       0, 0);
        run_case("R5 timeout but finished",      5,    4,       1, 0);
        run_case("R7 poll budget",               90000, 1000000, 0, 0);
        run_case("R2 start ignored while busy",  8,    1000000, 1, 1);
        run_case("R6 timeout slow bus",          1000, 2,       3, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule